// File: doc/BRIEF.md
# Indexed NVRAM byte window with region locks

This block puts a small byte store behind a four-location I/O window. A host never addresses the store directly. It loads a 16-bit pointer one byte at a time, low byte and high byte, and then reads or writes the byte that pointer selects through a single data location. After a data write the pointer returns to zero. A data read leaves the pointer as it is, so one location can be polled repeatedly.

Two lock bits each hide a fixed 16-byte region of the store, one at 0x20..0x2F and one at 0x30..0x3F. A separate toggle request inverts one selected lock bit. A hidden byte reads back as 0xFF and ignores writes. A size parameter bounds the store: pointers at or beyond it behave like hidden bytes. The store contents are not cleared by reset, as a battery-backed memory would keep them. The pointer and the locks are cleared by reset.

Each access is a one-cycle strobe that carries a 2-bit offset: 0 is the pointer low byte, 1 is the pointer high byte, 2 is unused and 3 is data. Read data appears on the output in the cycle after the strobe and holds until the next read strobe.

Top module: `nvram_window`

## Requirements
- R1: A write strobe at offset 0 replaces pointer bits [7:0] with the data byte and keeps bits [15:8].
- R2: A write strobe at offset 1 replaces pointer bits [15:8] with the data byte and keeps bits [7:0].
- R3: A write strobe at offset 3 stores the data byte at the pointer address when that address is open, then clears the whole pointer to zero.
- R4: A read strobe at offset 3 returns the byte at the pointer address on `acc_rdata` in the next cycle and leaves the pointer unchanged.
- R5: A read strobe at offset 0, 1 or 2 returns 0xFF in the next cycle. A write strobe at offset 2 changes neither the pointer nor the store.
- R6: While lock bit 0 is set, addresses 0x20..0x2F are hidden. While lock bit 1 is set, addresses 0x30..0x3F are hidden. A hidden read returns 0xFF and a hidden write is dropped. The other region and the addresses around them stay open.
- R7: A pointer at or above the store size (256 bytes by default) reads as 0xFF. A write there is dropped and does not alias onto a lower address.
- R8: A toggle request with index n inverts lock bit n only, effective from the next cycle. An access in the same cycle as the toggle sees the old lock state.
- R9: Reset clears the pointer and both lock bits and sets `acc_rdata` to 0xFF. The store contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_offset | input | 2 | Window offset: 0 pointer low, 1 pointer high, 2 unused, 3 data |
| acc_wdata | input | 8 | Write data byte |
| acc_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| lock_flip_valid | input | 1 | Toggle request for one lock bit |
| lock_flip_idx | input | 1 | Index of the lock bit to invert |

## Verification
The properties assume that the access and toggle inputs carry known values whenever reset is released. They also assume that each strobe lasts exactly one cycle, so the cycle after a strobe is an idle one. The stimulus drives every input on the falling edge, deasserts the strobe after one cycle and gives every field a defined value, including during idle cycles. The checks on read data cover only the fill value and locations that were written before. Unwritten store bytes have no defined value.

// File: rtl/nvram_window_pkg.sv
package nvram_window_pkg;

    // Window offsets presented on the 2-bit access port
    typedef enum logic [1:0] {
        OFS_PTR_LO = 2'd0,
        OFS_PTR_HI = 2'd1,
        OFS_SPARE  = 2'd2,
        OFS_DATA   = 2'd3
    } win_ofs_e;

    // Value returned for anything that is not a readable store byte
    localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/nvram_addr_latch.sv
module nvram_addr_latch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              clr,
    input  logic [7:0]        byte_in,
    output logic [ADDR_W-1:0] ptr
);

    localparam int HI_W = ADDR_W - 8;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ptr = '0;
        end else begin
            if (ld_lo) begin
                st_d.ptr[7:0] = byte_in;
            end
            if (ld_hi) begin
                st_d.ptr[ADDR_W-1:8] = byte_in[HI_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;

endmodule

// File: rtl/nvram_lock_bank.sv
module nvram_lock_bank #(
    parameter int ADDR_W       = 16,
    parameter int NUM_LOCKS    = 2,
    parameter int REGION_BYTES = 16,
    parameter int LOCK_BASE    = 32,
    parameter int IDX_W        = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flip_valid,
    input  logic [IDX_W-1:0]     flip_idx,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_LOCKS-1:0] locks,
    output logic                 blocked
);

    typedef struct packed {
        logic [NUM_LOCKS-1:0] locks;
    } lock_state_t;

    lock_state_t st_d, st_q;
    logic [NUM_LOCKS-1:0] region_hit;

    always_comb begin
        st_d = st_q;
        if (flip_valid) begin
            for (int i = 0; i < NUM_LOCKS; i++) begin
                if (flip_idx == IDX_W'(i)) begin
                    st_d.locks[i] = ~st_q.locks[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // One address window per lock bit, laid end to end from LOCK_BASE
    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_region
        localparam logic [ADDR_W:0] R_LO = (ADDR_W+1)'(LOCK_BASE + g * REGION_BYTES);
        localparam logic [ADDR_W:0] R_HI = (ADDR_W+1)'(LOCK_BASE + (g + 1) * REGION_BYTES);
        assign region_hit[g] = ({1'b0, addr} >= R_LO) && ({1'b0, addr} < R_HI);
    end

    assign locks   = st_q.locks;
    assign blocked = |(region_hit & st_q.locks);

endmodule

// File: rtl/nvram_byte_ram.sv
module nvram_byte_ram #(
    parameter int MEM_BYTES = 256,
    parameter int IDX_W     = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);

    // No reset: contents model battery-backed storage
    logic [7:0] mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/nvram_window.sv
module nvram_window #(
    parameter int ADDR_W       = 16,
    parameter int MEM_BYTES    = 256,
    parameter int NUM_LOCKS    = 2,
    parameter int REGION_BYTES = 16,
    parameter int LOCK_BASE    = 32,
    localparam int LOCK_IDX_W  = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [1:0]            acc_offset,
    input  logic [7:0]            acc_wdata,
    output logic [7:0]            acc_rdata,
    input  logic                  lock_flip_valid,
    input  logic [LOCK_IDX_W-1:0] lock_flip_idx
);

    import nvram_window_pkg::*;

    localparam int              RAM_IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;
    localparam logic [ADDR_W:0] MEM_LIMIT = (ADDR_W+1)'(MEM_BYTES);

    typedef struct packed {
        logic [7:0] rdata;
    } out_state_t;

    win_ofs_e             ofs;
    logic                 ptr_lo_wr, ptr_hi_wr, data_wr, data_rd, side_rd;
    logic                 in_range, blocked, ram_we;
    logic [ADDR_W-1:0]    latch_addr;
    logic [NUM_LOCKS-1:0] lock_vec;
    logic [7:0]           ram_q;
    out_state_t           out_d, out_q;

    // Offset decode
    assign ofs       = win_ofs_e'(acc_offset);
    assign ptr_lo_wr = acc_valid &&  acc_write && (ofs == OFS_PTR_LO);
    assign ptr_hi_wr = acc_valid &&  acc_write && (ofs == OFS_PTR_HI);
    assign data_wr   = acc_valid &&  acc_write && (ofs == OFS_DATA);
    assign data_rd   = acc_valid && !acc_write && (ofs == OFS_DATA);
    assign side_rd   = acc_valid && !acc_write && (ofs != OFS_DATA);

    assign in_range  = ({1'b0, latch_addr} < MEM_LIMIT);
    assign ram_we    = data_wr && in_range && !blocked;

    nvram_addr_latch #(
        .ADDR_W (ADDR_W)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (ptr_lo_wr),
        .ld_hi   (ptr_hi_wr),
        .clr     (data_wr),
        .byte_in (acc_wdata),
        .ptr     (latch_addr)
    );

    nvram_lock_bank #(
        .ADDR_W       (ADDR_W),
        .NUM_LOCKS    (NUM_LOCKS),
        .REGION_BYTES (REGION_BYTES),
        .LOCK_BASE    (LOCK_BASE),
        .IDX_W        (LOCK_IDX_W)
    ) u_locks (
        .clk        (clk),
        .rst_n      (rst_n),
        .flip_valid (lock_flip_valid),
        .flip_idx   (lock_flip_idx),
        .addr       (latch_addr),
        .locks      (lock_vec),
        .blocked    (blocked)
    );

    nvram_byte_ram #(
        .MEM_BYTES (MEM_BYTES),
        .IDX_W     (RAM_IDX_W)
    ) u_ram (
        .clk   (clk),
        .wr_en (ram_we),
        .idx   (latch_addr[RAM_IDX_W-1:0]),
        .wdata (acc_wdata),
        .rdata (ram_q)
    );

    // Read return path: registered, holds until the next read strobe
    always_comb begin
        out_d = out_q;
        if (data_rd) begin
            out_d.rdata = (in_range && !blocked) ? ram_q : FILL_BYTE;
        end else if (side_rd) begin
            out_d.rdata = FILL_BYTE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.rdata <= FILL_BYTE;
        end else begin
            out_q <= out_d;
        end
    end

    assign acc_rdata = out_q.rdata;

endmodule

// File: rtl/nvram_window_chk.sv
module nvram_window_chk #(
    parameter int ADDR_W       = 16,
    parameter int MEM_BYTES    = 256,
    parameter int NUM_LOCKS    = 2,
    parameter int REGION_BYTES = 16,
    parameter int LOCK_BASE    = 32,
    parameter int LOCK_IDX_W   = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_valid,
    input logic                  acc_write,
    input logic [1:0]            acc_offset,
    input logic [7:0]            acc_wdata,
    input logic [7:0]            acc_rdata,
    input logic                  lock_flip_valid,
    input logic [LOCK_IDX_W-1:0] lock_flip_idx,
    input logic [ADDR_W-1:0]     latch_addr,
    input logic [NUM_LOCKS-1:0]  lock_vec
);

    localparam logic [ADDR_W:0] MEM_LIMIT = (ADDR_W+1)'(MEM_BYTES);

    logic rd_any, rd_data;
    assign rd_any  = acc_valid && !acc_write;
    assign rd_data = rd_any && (acc_offset == 2'd3);

    AST_PTR_LO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_offset == 2'd0) |=>
        (latch_addr[7:0] == $past(acc_wdata)) && (latch_addr[ADDR_W-1:8] == $past(latch_addr[ADDR_W-1:8]))); // R1

    AST_PTR_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_offset == 2'd1) |=>
        (latch_addr[7:0] == $past(latch_addr[7:0]))); // R2

    AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_offset == 2'd3) |=> (latch_addr == '0)); // R3

    AST_READ_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data |=> $stable(latch_addr)); // R4

    AST_SIDE_READ_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && acc_offset != 2'd3) |=> (acc_rdata == 8'hFF)); // R5

    AST_SPARE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_offset == 2'd2) |=> $stable(latch_addr)); // R5

    AST_OUT_OF_RANGE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && ({1'b0, latch_addr} >= MEM_LIMIT)) |=> (acc_rdata == 8'hFF)); // R7

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock_chk
        localparam logic [ADDR_W:0] C_LO = (ADDR_W+1)'(LOCK_BASE + g * REGION_BYTES);
        localparam logic [ADDR_W:0] C_HI = (ADDR_W+1)'(LOCK_BASE + (g + 1) * REGION_BYTES);
        logic in_win;
        assign in_win = ({1'b0, latch_addr} >= C_LO) && ({1'b0, latch_addr} < C_HI);

        AST_LOCKED_READ_FILL: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data && in_win && lock_vec[g]) |=> (acc_rdata == 8'hFF)); // R6
    end

    AST_FLIP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flip_valid |=>
        ((lock_vec ^ $past(lock_vec)) == (NUM_LOCKS'(1) << $past(lock_flip_idx)))); // R8

    AST_LOCKS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_flip_valid |=> $stable(lock_vec)); // R8

endmodule

bind nvram_window nvram_window_chk #(
    .ADDR_W       (ADDR_W),
    .MEM_BYTES    (MEM_BYTES),
    .NUM_LOCKS    (NUM_LOCKS),
    .REGION_BYTES (REGION_BYTES),
    .LOCK_BASE    (LOCK_BASE),
    .LOCK_IDX_W   (LOCK_IDX_W)
) u_nvram_window_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_valid       (acc_valid),
    .acc_write       (acc_write),
    .acc_offset      (acc_offset),
    .acc_wdata       (acc_wdata),
    .acc_rdata       (acc_rdata),
    .lock_flip_valid (lock_flip_valid),
    .lock_flip_idx   (lock_flip_idx),
    .latch_addr      (latch_addr),
    .lock_vec        (lock_vec)
);

// File: tb/nvram_window_bench.sv
module nvram_window_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [1:0] acc_offset = 2'd0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] acc_rdata;
    logic       lock_flip_valid = 1'b0;
    logic [0:0] lock_flip_idx = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    nvram_window u_nvram_window (
        .clk             (clk),
        .rst_n           (rst_n),
        .acc_valid       (acc_valid),
        .acc_write       (acc_write),
        .acc_offset      (acc_offset),
        .acc_wdata       (acc_wdata),
        .acc_rdata       (acc_rdata),
        .lock_flip_valid (lock_flip_valid),
        .lock_flip_idx   (lock_flip_idx)
    );

    localparam logic [1:0] KW = 2'd0;  // write strobe
    localparam logic [1:0] KR = 2'd1;  // read strobe, compare
    localparam logic [1:0] KF = 2'd2;  // lock toggle, index in data[0]

    typedef struct packed {
        logic [1:0] kind;
        logic [1:0] off;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 58;
    localparam vec_t VECS [NV] = '{
        '{KW, 2'd3, 8'hC3, 8'h00, 4'd9},  // R9 pointer is zero after reset
        '{KR, 2'd3, 8'h00, 8'hC3, 4'd4},  // R4
        '{KW, 2'd0, 8'h10, 8'h00, 4'd1},
        '{KW, 2'd3, 8'hA5, 8'h00, 4'd3},
        '{KW, 2'd0, 8'h10, 8'h00, 4'd1},
        '{KR, 2'd3, 8'h00, 8'hA5, 4'd3},  // R3 store at pointer
        '{KR, 2'd3, 8'h00, 8'hA5, 4'd4},  // R4 pointer kept by read
        '{KW, 2'd0, 8'h11, 8'h00, 4'd1},
        '{KW, 2'd3, 8'h3C, 8'h00, 4'd3},
        '{KW, 2'd0, 8'h11, 8'h00, 4'd1},
        '{KR, 2'd3, 8'h00, 8'h3C, 4'd1},  // R1
        '{KW, 2'd1, 8'h01, 8'h00, 4'd2},
        '{KR, 2'd3, 8'h00, 8'hFF, 4'd7},  // R7 0x0111 beyond store
        '{KW, 2'd1, 8'h00, 8'h00, 4'd2},
        '{KR, 2'd3, 8'h00, 8'h3C, 4'd2},  // R2 low byte kept
        '{KW, 2'd0, 8'h10, 8'h00, 4'd1},
        '{KR, 2'd3, 8'h00, 8'hA5, 4'd1},  // R1 high byte kept
        '{KW, 2'd1, 8'h01, 8'h00, 4'd2},
        '{KW, 2'd3, 8'h77, 8'h00, 4'd7},  // write at 0x0110 dropped
        '{KW, 2'd0, 8'h10, 8'h00, 4'd1},
        '{KR, 2'd3, 8'h00, 8'hA5, 4'd7},  // R7 no alias onto 0x10
        '{KW, 2'd1, 8'h01, 8'h00, 4'd2},
        '{KW, 2'd0, 8'h11, 8'h00, 4'd1},
        '{KW, 2'd3, 8'h99, 8'h00, 4'd3},
        '{KR, 2'd3, 8'h00, 8'hC3, 4'd3},  // R3 both pointer bytes cleared
        '{KR, 2'd0, 8'h00, 8'hFF, 4'd5},  // R5
        '{KR, 2'd1, 8'h00, 8'hFF, 4'd5},  // R5
        '{KR, 2'd2, 8'h00, 8'hFF, 4'd5},  // R5
        '{KW, 2'd2, 8'h10, 8'h00, 4'd5},
        '{KR, 2'd3, 8'h00, 8'hC3, 4'd5},  // R5 spare write ignored
        '{KW, 2'd0, 8'h20, 8'h00, 4'd6},
        '{KW, 2'd3, 8'h21, 8'h00, 4'd6},
        '{KW, 2'd0, 8'h2F, 8'h00, 4'd6},
        '{KW, 2'd3, 8'h2E, 8'h00, 4'd6},
        '{KW, 2'd0, 8'h1F, 8'h00, 4'd6},
        '{KW, 2'd3, 8'h1E, 8'h00, 4'd6},
        '{KW, 2'd0, 8'h30, 8'h00, 4'd6},
        '{KW, 2'd3, 8'h31, 8'h00, 4'd6},
        '{KF, 2'd0, 8'h00, 8'h00, 4'd8},  // lock 0 on
        '{KW, 2'd0, 8'h20, 8'h00, 4'd6},
        '{KR, 2'd3, 8'h00, 8'hFF, 4'd6},  // R6 first byte hidden
        '{KW, 2'd0, 8'h2F, 8'h00, 4'd6},
        '{KR, 2'd3, 8'h00, 8'hFF, 4'd6},  // R6 last byte hidden
        '{KW, 2'd0, 8'h1F, 8'h00, 4'd6},
        '{KR, 2'd3, 8'h00, 8'h1E, 4'd6},  // R6 byte below open
        '{KW, 2'd0, 8'h30, 8'h00, 4'd6},
        '{KR, 2'd3, 8'h00, 8'h31, 4'd6},  // R6 other region open
        '{KW, 2'd0, 8'h20, 8'h00, 4'd6},
        '{KW, 2'd3, 8'h55, 8'h00, 4'd6},  // hidden write
        '{KF, 2'd0, 8'h01, 8'h00, 4'd8},  // lock 1 on
        '{KW, 2'd0, 8'h30, 8'h00, 4'd6},
        '{KR, 2'd3, 8'h00, 8'hFF, 4'd6},  // R6 second region hidden
        '{KF, 2'd0, 8'h00, 8'h00, 4'd8},  // lock 0 off
        '{KW, 2'd0, 8'h20, 8'h00, 4'd6},
        '{KR, 2'd3, 8'h00, 8'h21, 4'd8},  // R8 reopened, R6 write dropped
        '{KF, 2'd0, 8'h01, 8'h00, 4'd8},  // lock 1 off
        '{KW, 2'd0, 8'h30, 8'h00, 4'd6},
        '{KR, 2'd3, 8'h00, 8'h31, 4'd8}   // R8 second lock off again
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic wr, input logic [1:0] off, input logic [7:0] d);
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_offset = off;
        acc_wdata  = d;
        @(negedge clk);
        acc_valid  = 1'b0;
        acc_write  = 1'b0;
    endtask

    task automatic flip(input logic idx);
        @(negedge clk);
        lock_flip_valid = 1'b1;
        lock_flip_idx   = idx;
        @(negedge clk);
        lock_flip_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R9 rdata during reset", acc_rdata, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 rdata after reset", acc_rdata, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].kind)
                KW: strobe(1'b1, VECS[i].off, VECS[i].data);
                KR: begin
                    strobe(1'b0, VECS[i].off, 8'h00);
                    check($sformatf("R%0d vector %0d", VECS[i].req, i), acc_rdata, VECS[i].exp);
                end
                default: flip(VECS[i].data[0]);
            endcase
        end

        // R8: access in the same cycle as a toggle sees the old lock state
        strobe(1'b1, 2'd0, 8'h20);
        @(negedge clk);
        acc_valid       = 1'b1;
        acc_write       = 1'b0;
        acc_offset      = 2'd3;
        lock_flip_valid = 1'b1;
        lock_flip_idx   = 1'b0;
        @(negedge clk);
        acc_valid       = 1'b0;
        lock_flip_valid = 1'b0;
        check("R8 same-cycle toggle uses old lock", acc_rdata, 8'h21);
        strobe(1'b0, 2'd3, 8'h00);
        check("R8 lock takes effect next cycle", acc_rdata, 8'hFF);

        // R9: reset mid-run clears pointer and locks, keeps the store
        flip(1'b1);
        strobe(1'b1, 2'd0, 8'h11);
        strobe(1'b0, 2'd3, 8'h00);
        check("R6 read before reset", acc_rdata, 8'h3C);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 rdata in mid-run reset", acc_rdata, 8'hFF);
        rst_n = 1'b1;
        strobe(1'b0, 2'd3, 8'h00);
        check("R9 pointer cleared, store kept", acc_rdata, 8'hC3);
        strobe(1'b1, 2'd0, 8'h20);
        strobe(1'b0, 2'd3, 8'h00);
        check("R9 lock 0 cleared", acc_rdata, 8'h21);
        strobe(1'b1, 2'd0, 8'h30);
        strobe(1'b0, 2'd3, 8'h00);
        check("R9 lock 1 cleared", acc_rdata, 8'h31);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule